// File: doc/BRIEF.md
# Power-Gating Controller with Acknowledge Handshake

This block switches nine power domains on and off under software control. Software writes a request bit for each domain into one 32-bit control register. Software then polls a separate acknowledge bit for that domain in the same register. Each request bit and its acknowledge bit sit at fixed positions that are not adjacent. A driver therefore decodes the pairs through a fixed table.

When a request bit changes, the domain's own sequencer runs the power-up order or the power-down order. Power-up turns on the power switch and waits a settle count that models the analog switch. It then drops isolation, releases the domain reset and finally reports the acknowledge. Power-down runs the same steps in reverse.

The domain index used on the per-domain output buses maps to the request bits as follows: index 0..8 maps to request bits 0, 1, 2, 5, 6, 8, 9, 10, 11. Domains 3 and 4 (request bits 5 and 6) leave reset already powered.

Top module: `power_gate_ctrl`

## Requirements
- R1: Request bits for domains 0..8 are stored at register bits 0, 1, 2, 5, 6, 8, 9, 10, 11 and read back from the same bits. Every register bit that holds neither a request nor an acknowledge reads 0, and writes to it have no effect.
- R2: The acknowledge bits of domains 0..8 read at register bits 16, 17, 18, 21, 22, 12, 13, 14, 15. These bits are read-only, so a value written to them changes neither the readback nor any domain.
- R3: Power-up, with the request bit written on clock edge W and a settle count S: the switch enable rises after edge W+1, isolation drops after edge W+S+1, the domain reset is released after edge W+S+2, and the acknowledge reads 1 after edge W+S+3.
- R4: Power-down, with the request bit cleared on edge W: the domain reset asserts after edge W+1, isolation asserts after edge W+2, the switch enable falls after edge W+3, and the acknowledge reads 0 after edge W+S+3.
- R5: The acknowledge turns to 1 only when the domain is fully on (switch on, isolation off, reset released). It turns to 0 only when the domain is fully off. During a sequence it keeps its previous value.
- R6: Writing a request value equal to the domain's current settled state starts no sequence and leaves all of the domain's outputs and its acknowledge unchanged.
- R7: If a request bit changes while its domain is mid-sequence, the running sequence completes. If the request then differs from the reached state, the opposite sequence starts on the next edge. Example: request 1 on edge W, then 0 on edge W+1; the acknowledge is 1 from edge W+S+3 and 0 from edge W+2S+6.
- R8: After reset, domains 3 and 4 are fully on with request and acknowledge bits set (readback 0x00600060). All other domains are off, with switch off, isolation on and reset asserted.
- R9: Domains sequence independently. One write may start several domains at once, and each completes on its own timing.
- R10: Isolation is released only while the switch is on. The domain reset is released only while isolation is released. The switch changes state only while isolation and reset are both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrite | input | 1 | Write strobe for the control register |
| regWdata | input | 32 | Write data for the control register |
| regRdata | output | 32 | Control register readback (requests and acknowledges) |
| switchOn | output | 9 | Per-domain power-switch enable, indexed by domain |
| isolate | output | 9 | Per-domain isolation control, 1 = isolated |
| domainReset | output | 9 | Per-domain reset, 1 = held in reset |

## Verification
On every cycle, the assertions check the safety ordering between switch, isolation and reset. They also check that the acknowledge changes only at a fully-on or fully-off point, and that a settle counter is never reloaded while it runs. Only the bench scenarios can show the exact cycle on which each output moves after a write. The same holds for the bit-position mapping of the register, for the ignored writes to acknowledge and unused bits, and for a request flipped mid-sequence finishing before its reversal.

// File: rtl/pg_pkg.sv
package pg_pkg;

  localparam int NUM_DOM = 9;
  localparam int REG_W   = 32;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_UP_SETTLE,
    ST_UP_ISO,
    ST_UP_RST,
    ST_ON,
    ST_DN_RST,
    ST_DN_ISO,
    ST_DN_SETTLE
  } pgState_e;

  // Strobes from the sequencers to the datapath.
  typedef struct packed {
    logic cntLoad;
    logic ackSet;
    logic ackClr;
  } pgStrobe_t;

  // Register bit holding the request of a domain (fixed by software contract).
  function automatic int reqPos(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 5;
      4: return 6;
      5: return 8;
      6: return 9;
      7: return 10;
      default: return 11;
    endcase
  endfunction

  // Register bit holding the acknowledge of a domain.
  function automatic int ackPos(input int idx);
    case (idx)
      0: return 16;
      1: return 17;
      2: return 18;
      3: return 21;
      4: return 22;
      5: return 12;
      6: return 13;
      7: return 14;
      default: return 15;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reqMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_DOM; i++) m[reqPos(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pg_datapath.sv
module pg_datapath
  import pg_pkg::*;
#(
  parameter int                 SETTLE_CYCLES  = 16,
  parameter logic [NUM_DOM-1:0] ALWAYS_ON_MASK = 9'h018
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWrite,
  input  logic [REG_W-1:0]             regWdata,
  input  pgStrobe_t [NUM_DOM-1:0]      strobes,
  output logic [NUM_DOM-1:0]           reqVec,
  output logic [NUM_DOM-1:0]           ackVec,
  output logic [NUM_DOM-1:0]           cntDone,
  output logic [REG_W-1:0]             regRdata
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [REG_W-1:0] REQ_MASK = reqMask();

  logic [NUM_DOM-1:0] reqQ;
  logic [NUM_DOM-1:0] ackQ;

  // Only the request positions are stored; the rest of the write is dropped.
  logic unusedWrBits;
  assign unusedWrBits = ^(regWdata & ~REQ_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= ALWAYS_ON_MASK;
    end else if (regWrite) begin
      for (int i = 0; i < NUM_DOM; i++) reqQ[i] <= regWdata[reqPos(i)];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ <= ALWAYS_ON_MASK;
    end else begin
      for (int i = 0; i < NUM_DOM; i++) begin
        if (strobes[i].ackSet)      ackQ[i] <= 1'b1;
        else if (strobes[i].ackClr) ackQ[i] <= 1'b0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_DOM; g++) begin : gSettle
      logic [CNT_W-1:0] cntQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   cntQ <= '0;
        else if (strobes[g].cntLoad) cntQ <= CNT_W'(SETTLE_CYCLES);
        else if (cntQ != '0)         cntQ <= cntQ - 1'b1;
      end

      assign cntDone[g] = (cntQ == CNT_W'(1));

      // R3: the settle window never exceeds its configured length
      p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
        cntQ <= CNT_W'(SETTLE_CYCLES));

      // R7: a settle count is never restarted while still running
      p_load_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
        strobes[g].cntLoad |-> (cntQ == '0));
    end
  endgenerate

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_DOM; i++) begin
      regRdata[reqPos(i)] = reqQ[i];
      regRdata[ackPos(i)] = ackQ[i];
    end
  end

  assign reqVec = reqQ;
  assign ackVec = ackQ;

endmodule

// File: rtl/pg_control.sv
module pg_control
  import pg_pkg::*;
#(
  parameter logic [NUM_DOM-1:0] ALWAYS_ON_MASK = 9'h018
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_DOM-1:0]      reqVec,
  input  logic [NUM_DOM-1:0]      ackVec,
  input  logic [NUM_DOM-1:0]      cntDone,
  output pgStrobe_t [NUM_DOM-1:0] strobes,
  output logic [NUM_DOM-1:0]      switchOn,
  output logic [NUM_DOM-1:0]      isolate,
  output logic [NUM_DOM-1:0]      domainReset
);

  genvar g;
  generate
    for (g = 0; g < NUM_DOM; g++) begin : gSeq
      localparam pgState_e RST_STATE = ALWAYS_ON_MASK[g] ? ST_ON : ST_OFF;

      pgState_e  stateQ, stateD;
      pgStrobe_t strobe;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stateQ <= RST_STATE;
        else       stateQ <= stateD;
      end

      always_comb begin
        stateD = stateQ;
        strobe = '0;
        unique case (stateQ)
          ST_OFF: if (reqVec[g]) begin
            stateD         = ST_UP_SETTLE;
            strobe.cntLoad = 1'b1;
          end
          ST_UP_SETTLE: if (cntDone[g]) stateD = ST_UP_ISO;
          ST_UP_ISO:    stateD = ST_UP_RST;
          ST_UP_RST: begin
            stateD        = ST_ON;
            strobe.ackSet = 1'b1;
          end
          ST_ON:     if (!reqVec[g]) stateD = ST_DN_RST;
          ST_DN_RST: stateD = ST_DN_ISO;
          ST_DN_ISO: begin
            stateD         = ST_DN_SETTLE;
            strobe.cntLoad = 1'b1;
          end
          ST_DN_SETTLE: if (cntDone[g]) begin
            stateD        = ST_OFF;
            strobe.ackClr = 1'b1;
          end
          default: stateD = ST_OFF;
        endcase
      end

      assign strobes[g]     = strobe;
      assign switchOn[g]    = !(stateQ == ST_OFF || stateQ == ST_DN_SETTLE);
      assign isolate[g]     = (stateQ == ST_OFF) || (stateQ == ST_UP_SETTLE) ||
                              (stateQ == ST_DN_ISO) || (stateQ == ST_DN_SETTLE);
      assign domainReset[g] = !(stateQ == ST_UP_RST || stateQ == ST_ON);

      // R5: acknowledge rises only at the fully powered point
      p_ack_rise_full_r5: assert property (@(posedge clk) disable iff (!rstN)
        $rose(ackVec[g]) |-> (switchOn[g] && !isolate[g] && !domainReset[g]));

      // R5: acknowledge falls only at the fully off point
      p_ack_fall_off_r5: assert property (@(posedge clk) disable iff (!rstN)
        $fell(ackVec[g]) |-> (!switchOn[g] && isolate[g] && domainReset[g]));

      // R10: isolation open implies switch powered
      p_iso_needs_switch_r10: assert property (@(posedge clk) disable iff (!rstN)
        !isolate[g] |-> switchOn[g]);

      // R10: reset released implies isolation open
      p_rst_needs_iso_r10: assert property (@(posedge clk) disable iff (!rstN)
        !domainReset[g] |-> !isolate[g]);

      // R10: switch toggles only while isolated and held in reset
      p_switch_edge_safe_r10: assert property (@(posedge clk) disable iff (!rstN)
        ($rose(switchOn[g]) || $fell(switchOn[g])) |-> (isolate[g] && domainReset[g]));

      // R6: a settled domain whose request matches its acknowledge stays put
      p_hold_matched_r6: assert property (@(posedge clk) disable iff (!rstN)
        ((reqVec[g] == ackVec[g]) && $stable(reqVec[g]) &&
         (switchOn[g] == !isolate[g]) && (isolate[g] == domainReset[g]) &&
         (switchOn[g] == ackVec[g]))
        |=> ($stable(switchOn[g]) && $stable(isolate[g]) && $stable(ackVec[g])));
    end
  endgenerate

endmodule

// File: rtl/power_gate_ctrl.sv
module power_gate_ctrl
  import pg_pkg::*;
#(
  parameter int                 SETTLE_CYCLES  = 16,
  parameter logic [NUM_DOM-1:0] ALWAYS_ON_MASK = 9'h018
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrite,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  output logic [NUM_DOM-1:0] switchOn,
  output logic [NUM_DOM-1:0] isolate,
  output logic [NUM_DOM-1:0] domainReset
);

  pgStrobe_t [NUM_DOM-1:0] strobes;
  logic [NUM_DOM-1:0]      reqVec;
  logic [NUM_DOM-1:0]      ackVec;
  logic [NUM_DOM-1:0]      cntDone;

  pg_datapath #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .ALWAYS_ON_MASK(ALWAYS_ON_MASK)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .regWrite(regWrite),
    .regWdata(regWdata),
    .strobes (strobes),
    .reqVec  (reqVec),
    .ackVec  (ackVec),
    .cntDone (cntDone),
    .regRdata(regRdata)
  );

  pg_control #(
    .ALWAYS_ON_MASK(ALWAYS_ON_MASK)
  ) uControl (
    .clk        (clk),
    .rstN       (rstN),
    .reqVec     (reqVec),
    .ackVec     (ackVec),
    .cntDone    (cntDone),
    .strobes    (strobes),
    .switchOn   (switchOn),
    .isolate    (isolate),
    .domainReset(domainReset)
  );

endmodule

// File: tb/tb_power_gate_ctrl.sv
module tb_power_gate_ctrl;

  localparam int S     = 6;
  localparam int NVEC  = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrite;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic [8:0]  switchOn, isolate, domainReset;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  power_gate_ctrl #(.SETTLE_CYCLES(S), .ALWAYS_ON_MASK(9'h018)) dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regWdata(regWdata),
    .regRdata(regRdata), .switchOn(switchOn), .isolate(isolate),
    .domainReset(domainReset)
  );

  // Write value, expected readback, expected powered-domain vector.
  localparam logic [31:0] VEC_WR [NVEC] = '{32'h0000_0001, 32'h0000_0F00,
    32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_0064, 32'h0000_0A90};
  localparam logic [31:0] VEC_RD [NVEC] = '{32'h0001_0001, 32'h0000_FF00,
    32'h0067_FF67, 32'h0000_0000, 32'h0064_0064, 32'h0000_AA00};
  localparam logic [8:0]  VEC_DOM [NVEC] = '{9'h001, 9'h1E0, 9'h1FF,
    9'h000, 9'h01C, 9'h140};
  localparam string VEC_REQ [NVEC] = '{"R1", "R9", "R1", "R2", "R9", "R1"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1;
    regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic chkDomains(input string req, input logic [8:0] dom);
    chk(req, {23'd0, switchOn}, {23'd0, dom});
    chk(req, {23'd0, isolate}, {23'd0, ~dom});
    chk(req, {23'd0, domainReset}, {23'd0, ~dom});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    regWrite = 1'b0;
    regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: reset state
    chk("R8", regRdata, 32'h0060_0060);
    chkDomains("R8", 9'h018);

    // R1 R2 R9: table of register patterns
    for (int v = 0; v < NVEC; v++) begin
      writeReg(VEC_WR[v]);
      repeat (2 * S + 10) @(negedge clk);
      chk(VEC_REQ[v], regRdata, VEC_RD[v]);
      chkDomains(VEC_REQ[v], VEC_DOM[v]);
    end

    // Bring everything off before directed timing tests.
    writeReg(32'h0);
    repeat (2 * S + 10) @(negedge clk);
    chk("R2", regRdata, 32'h0);

    // R3 R5: power-up timing of domain 0 (k counts edges after the write edge)
    writeReg(32'h1);
    chk("R3", {31'd0, switchOn[0]}, 32'd0);
    for (int k = 1; k <= S + 4; k++) begin
      @(negedge clk);
      chk("R3", {31'd0, switchOn[0]}, 32'd1);
      chk("R3", {31'd0, isolate[0]}, {31'd0, (k < S + 1)});
      chk("R3", {31'd0, domainReset[0]}, {31'd0, (k < S + 2)});
      chk("R5", {31'd0, regRdata[16]}, {31'd0, (k >= S + 3)});
    end

    // R6: rewrite same value, nothing moves
    writeReg(32'h1);
    for (int k = 1; k <= S + 4; k++) begin
      @(negedge clk);
      chk("R6", {23'd0, switchOn}, 32'h001);
      chk("R6", {23'd0, isolate}, 32'h1FE);
      chk("R6", regRdata, 32'h0001_0001);
    end

    // R4 R5: power-down timing of domain 0
    writeReg(32'h0);
    for (int k = 1; k <= S + 4; k++) begin
      @(negedge clk);
      chk("R4", {31'd0, domainReset[0]}, 32'd1);
      chk("R4", {31'd0, isolate[0]}, {31'd0, (k >= 2)});
      chk("R4", {31'd0, switchOn[0]}, {31'd0, (k < 3)});
      chk("R5", {31'd0, regRdata[16]}, {31'd0, (k < S + 3)});
    end

    // R7: request flipped mid-sequence
    writeReg(32'h1);
    regWrite = 1'b1;
    regWdata = 32'h0;
    @(negedge clk);
    regWrite = 1'b0;
    for (int k = 2; k <= 2 * S + 8; k++) begin
      @(negedge clk);
      chk("R7", {31'd0, regRdata[16]}, {31'd0, (k >= S + 3) && (k < 2 * S + 6)});
      if (k == S + 3) chkDomains("R7", 9'h001);
    end
    chk("R7", regRdata, 32'h0);
    chkDomains("R7", 9'h000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule